// File: doc/BRIEF.md
# Memory Clock-Stop Gating Controller

This block sits between the command sequencer of a low-power DDR memory and the driver of the memory clock, and decides when that clock may be halted. Each access command the sequencer issues demands a minimum number of further clock pulses before the clock may stop. The block looks up that number for the command and holds it in a down-counter. While the counter is nonzero, a request to stop the clock is not acted on. Once the counter has drained and the sequencer is issuing only NOPs, the block grants the stop and drops the clock enable.

While the clock is stopped, a flag tells the system that the clock frequency may be changed. A resume request is honoured only when the system reports the new clock as stable. The clock then restarts, but the ready-for-command flag stays low for a parameterised exit time. Commands presented while that flag is low are ignored. The memory clock-enable pin is not driven by this block and stays high throughout. All three outputs are registers on the free-running system clock.

The per-command pulse counts are derived from parameters (burst length, CAS latency, precharge, write recovery, refresh and mode-set times), so other clock rates can be supported. The defaults give the counts for a 133 MHz memory clock.

Top module: `memclk_stop_ctrl`

## Requirements
- R1: After reset, `mclk_en` is 1, `cmd_ready` is 1 and `freq_chg_ok` is 0.
- R2: With `stop_req` held from the command cycle onward, `mclk_en` goes low cost+1 edges after the edge that samples the command. The cost is 3 for activate, 3 for precharge and 2 for mode set.
- R3: A read or a write without auto-precharge costs 5 pulses (burst length 4, CAS latency 3).
- R4: A read with auto-precharge costs the larger of (burst/2 + precharge time) and (burst/2 + CAS latency), which is 5. A write with auto-precharge costs 1 + burst/2 + auto-precharge write recovery, which is 8. A refresh costs 10.
- R5: `stop_req` has no effect while the pending pulse count is nonzero.
- R6: A stop is granted only in a cycle whose `cmd` is not an access command.
- R7: A command accepted while a count is running loads the larger of the remaining count and its own cost.
- R8: `freq_chg_ok` is 1 exactly while the clock is stopped. It rises together with the fall of `mclk_en` and falls together with its rise.
- R9: In the stopped state, `resume_req` is acted on only when `clk_stable` is 1. `mclk_en` then rises on that same edge.
- R10: `cmd_ready` is 0 while the clock is stopped. It returns to 1 exactly T_EXIT (default 2) edges after the resume edge.
- R11: Commands presented while `cmd_ready` is 0 are ignored and load no count.
- R12: `cmd` encoding: 0 NOP, 1 activate, 2 read, 3 read with auto-precharge, 4 write, 5 write with auto-precharge, 6 precharge, 7 refresh, 8 mode set. The codes 9 to 15 are treated as NOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 4 | Command issued this cycle, encoding per R12 |
| stop_req | input | 1 | Request to halt the memory clock |
| resume_req | input | 1 | Request to restart the memory clock |
| clk_stable | input | 1 | New clock frequency is stable |
| mclk_en | output | 1 | Gated memory clock enable |
| cmd_ready | output | 1 | Sequencer may issue a valid command |
| freq_chg_ok | output | 1 | Clock frequency may be changed now |

## Verification
A wrong pending count shows up at `mclk_en`. A count that is too short makes the clock fall earlier than cost+1 edges after the command. A lost reload makes it fall too early after a second command. A stuck count keeps the clock running until the bench gives up. The bench measures the fall edge for every command cost and for one overlapping pair, and compares each result against a queue of expected latencies. A bad state register shows within one or two edges of a stop or resume, as a wrong `freq_chg_ok` or `cmd_ready`, or as a premature stop after a command that should have been ignored.

// File: rtl/memclk_pkg.sv
package memclk_pkg;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_ACT  = 4'd1,
        CMD_RD   = 4'd2,
        CMD_RDA  = 4'd3,
        CMD_WR   = 4'd4,
        CMD_WRA  = 4'd5,
        CMD_PRE  = 4'd6,
        CMD_REF  = 4'd7,
        CMD_MRS  = 4'd8
    } mem_cmd_e;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_STOPPED = 2'd1,
        ST_EXIT    = 2'd2
    } gate_state_e;

endpackage

// File: rtl/memclk_cmd_cost.sv
module memclk_cmd_cost
    import memclk_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int CAS_LAT   = 3,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_WR      = 2,
    parameter int T_DAL     = 5,
    parameter int T_RFC     = 10,
    parameter int T_MRD     = 2,
    parameter int CW        = 6
) (
    input  logic [3:0]    cmd_i,
    output logic [CW-1:0] cost_o,
    output logic          access_o
);
    localparam int HALF_BL   = BURST_LEN / 2;
    localparam int RD_COST   = HALF_BL + CAS_LAT;
    localparam int RDA_PRE   = HALF_BL + T_RP;
    localparam int RDA_COST  = (RDA_PRE > RD_COST) ? RDA_PRE : RD_COST;
    localparam int WR_COST   = 1 + HALF_BL + T_WR;
    localparam int WRA_COST  = 1 + HALF_BL + T_DAL;

    always_comb begin
        access_o = 1'b1;
        cost_o   = '0;
        case (cmd_i)
            CMD_ACT: cost_o = CW'(T_RCD);
            CMD_RD:  cost_o = CW'(RD_COST);
            CMD_RDA: cost_o = CW'(RDA_COST);
            CMD_WR:  cost_o = CW'(WR_COST);
            CMD_WRA: cost_o = CW'(WRA_COST);
            CMD_PRE: cost_o = CW'(T_RP);
            CMD_REF: cost_o = CW'(T_RFC);
            CMD_MRS: cost_o = CW'(T_MRD);
            default: access_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/memclk_pulse_cnt.sv
module memclk_pulse_cnt #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] cost_i,
    input  logic          tick_i,
    output logic          zero_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = (cost_i > cnt_q) ? cost_i : cnt_q;
        end else if (tick_i && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // R7: a reload never shortens the pending count
    assert_reload_keeps_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q >= $past(cost_i)) && (cnt_q >= $past(cnt_q)));

    // R11: without a load the count never grows
    assert_no_growth_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> cnt_q <= $past(cnt_q));

endmodule

// File: rtl/memclk_stop_ctrl.sv
module memclk_stop_ctrl
    import memclk_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int CAS_LAT   = 3,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_WR      = 2,
    parameter int T_DAL     = 5,
    parameter int T_RFC     = 10,
    parameter int T_MRD     = 2,
    parameter int T_EXIT    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] cmd,
    input  logic       stop_req,
    input  logic       resume_req,
    input  logic       clk_stable,
    output logic       mclk_en,
    output logic       cmd_ready,
    output logic       freq_chg_ok
);
    localparam int COST_SUM = T_RFC + T_DAL + T_WR + BURST_LEN + CAS_LAT
                            + T_RP + T_RCD + T_MRD + 2;
    localparam int CW  = $clog2(COST_SUM);
    localparam int EXW = (T_EXIT < 2) ? 1 : $clog2(T_EXIT + 1);

    typedef struct packed {
        gate_state_e    state;
        logic           mclk_en;
        logic           ready;
        logic           freq_ok;
        logic [EXW-1:0] exit_cnt;
    } ctrl_regs_t;

    ctrl_regs_t    reg_d, reg_q;
    logic [CW-1:0] cost;
    logic          is_access;
    logic          load, tick, cnt_zero;

    memclk_cmd_cost #(
        .BURST_LEN(BURST_LEN), .CAS_LAT(CAS_LAT), .T_RCD(T_RCD), .T_RP(T_RP),
        .T_WR(T_WR), .T_DAL(T_DAL), .T_RFC(T_RFC), .T_MRD(T_MRD), .CW(CW)
    ) u_cost (
        .cmd_i    (cmd),
        .cost_o   (cost),
        .access_o (is_access)
    );

    memclk_pulse_cnt #(.CW(CW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .cost_i (cost),
        .tick_i (tick),
        .zero_o (cnt_zero)
    );

    always_comb begin
        reg_d = reg_q;
        load  = 1'b0;
        tick  = 1'b0;
        case (reg_q.state)
            ST_RUN: begin
                load = is_access;
                tick = !is_access;
                if (stop_req && !is_access && cnt_zero) begin
                    reg_d.state   = ST_STOPPED;
                    reg_d.mclk_en = 1'b0;
                    reg_d.ready   = 1'b0;
                    reg_d.freq_ok = 1'b1;
                end
            end
            ST_STOPPED: begin
                if (resume_req && clk_stable) begin
                    reg_d.state    = ST_EXIT;
                    reg_d.mclk_en  = 1'b1;
                    reg_d.freq_ok  = 1'b0;
                    reg_d.exit_cnt = EXW'(T_EXIT);
                end
            end
            ST_EXIT: begin
                if (reg_q.exit_cnt <= EXW'(1)) begin
                    reg_d.state    = ST_RUN;
                    reg_d.ready    = 1'b1;
                    reg_d.exit_cnt = '0;
                end else begin
                    reg_d.exit_cnt = reg_q.exit_cnt - 1'b1;
                end
            end
            default: reg_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q.state    <= ST_RUN;
            reg_q.mclk_en  <= 1'b1;
            reg_q.ready    <= 1'b1;
            reg_q.freq_ok  <= 1'b0;
            reg_q.exit_cnt <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign mclk_en     = reg_q.mclk_en;
    assign cmd_ready   = reg_q.ready;
    assign freq_chg_ok = reg_q.freq_ok;

    // R5: the clock only falls after the pulse count drained under a request
    assert_stop_after_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mclk_en) |-> $past(cnt_zero) && $past(stop_req));

    // R6: the stop cycle carries no access command
    assert_stop_on_nop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mclk_en) |-> $past(!is_access));

    // R8: frequency change only with the clock halted
    assert_freq_only_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        freq_chg_ok |-> !mclk_en);

    // R9: restart requires a stable clock report
    assert_resume_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mclk_en) |-> $past(resume_req && clk_stable));

    // R10: ready never shown with the clock halted
    assert_ready_needs_clock_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> mclk_en);

    // R10: ready returns only after the clock already ran a cycle
    assert_ready_after_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_ready) |-> $past(mclk_en));

endmodule

// File: tb/memclk_stop_ctrl_bench.sv
module memclk_stop_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cmd = 4'd0;
    logic       stop_req = 1'b0;
    logic       resume_req = 1'b0;
    logic       clk_stable = 1'b0;
    logic       mclk_en, cmd_ready, freq_chg_ok;

    int n_chk  = 0;
    int n_fail = 0;
    int since  = 0;
    int exp_q[$];
    logic prev_en = 1'b1;

    always #10 clk = ~clk;

    memclk_stop_ctrl u_memclk_stop_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .stop_req(stop_req),
        .resume_req(resume_req), .clk_stable(clk_stable),
        .mclk_en(mclk_en), .cmd_ready(cmd_ready), .freq_chg_ok(freq_chg_ok)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // edges since the last accepted access command (R12 codes 1..8)
    always @(posedge clk) begin
        if (cmd_ready && cmd >= 4'd1 && cmd <= 4'd8) since <= 0;
        else                                          since <= since + 1;
    end

    // scoreboard monitor: compare stop latency on each clock fall
    always @(negedge clk) begin
        if (rst_n && prev_en && !mclk_en && exp_q.size() > 0) begin
            int e;
            e = exp_q.pop_front();
            chk(since == e, "R2 R3 R4 R5 R7 stop latency", since, e);
        end
        prev_en <= mclk_en;
    end

    task automatic do_resume();
        @(negedge clk);
        stop_req = 1'b0; resume_req = 1'b1; clk_stable = 1'b1;
        @(negedge clk);
        resume_req = 1'b0;
        chk(mclk_en == 1'b1, "R9 clock restarts", mclk_en, 1);
        chk(freq_chg_ok == 1'b0, "R8 flag drops on restart", freq_chg_ok, 0);
        chk(cmd_ready == 1'b0, "R10 exit holdoff first edge", cmd_ready, 0);
        @(negedge clk);
        chk(cmd_ready == 1'b0, "R10 exit holdoff second edge", cmd_ready, 0);
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R10 ready after exit", cmd_ready, 1);
    endtask

    task automatic run_stop(input logic [3:0] c, input int exp, input string req);
        @(negedge clk);
        cmd = c; stop_req = 1'b1;
        exp_q.push_back(exp);
        @(negedge clk);
        cmd = 4'd0;
        chk(mclk_en == 1'b1, {"R6 no stop with command ", req}, mclk_en, 1);
        for (int i = 0; i < 40 && mclk_en; i++) @(negedge clk);
        chk(freq_chg_ok == 1'b1, "R8 flag while stopped", freq_chg_ok, 1);
        chk(cmd_ready == 1'b0, "R10 not ready while stopped", cmd_ready, 0);
        do_resume();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mclk_en == 1'b1, "R1 reset mclk_en", mclk_en, 1);
        chk(cmd_ready == 1'b1, "R1 reset cmd_ready", cmd_ready, 1);
        chk(freq_chg_ok == 1'b0, "R1 reset freq_chg_ok", freq_chg_ok, 0);

        run_stop(4'd1, 4,  "R2 activate");
        run_stop(4'd6, 4,  "R2 precharge");
        run_stop(4'd8, 3,  "R2 mode set");
        run_stop(4'd2, 6,  "R3 read");
        run_stop(4'd4, 6,  "R3 write");
        run_stop(4'd3, 6,  "R4 read autoprecharge");
        run_stop(4'd5, 9,  "R4 write autoprecharge");
        run_stop(4'd7, 11, "R4 refresh");

        // R7: refresh then activate; the count stays at the refresh remainder
        @(negedge clk); cmd = 4'd7;
        @(negedge clk); cmd = 4'd0;
        @(negedge clk); cmd = 4'd1; stop_req = 1'b1; exp_q.push_back(10);
        @(negedge clk); cmd = 4'd0;
        for (int i = 0; i < 40 && mclk_en; i++) @(negedge clk);
        chk(mclk_en == 1'b0, "R7 stopped after overlap", mclk_en, 0);
        do_resume();

        // R12: an unused code acts as NOP, so a stop is granted at once
        @(negedge clk); cmd = 4'd9; stop_req = 1'b1;
        @(negedge clk); cmd = 4'd0;
        chk(mclk_en == 1'b0, "R12 unused code is NOP", mclk_en, 0);
        stop_req = 1'b0;

        // R11: refresh while stopped is ignored; R9: resume without stable clock
        cmd = 4'd7;
        resume_req = 1'b1; clk_stable = 1'b0;
        @(negedge clk); cmd = 4'd0;
        @(negedge clk);
        chk(mclk_en == 1'b0, "R9 resume ignored when unstable", mclk_en, 0);
        chk(freq_chg_ok == 1'b1, "R8 flag held while stopped", freq_chg_ok, 1);
        resume_req = 1'b0;
        do_resume();
        @(negedge clk); stop_req = 1'b1;
        @(negedge clk);
        chk(mclk_en == 1'b0, "R11 command while not ready ignored", mclk_en, 0);
        do_resume();

        // R5: stop held during a count keeps the clock running mid-count
        @(negedge clk); cmd = 4'd7; stop_req = 1'b1; exp_q.push_back(11);
        @(negedge clk); cmd = 4'd0;
        repeat (5) @(negedge clk);
        chk(mclk_en == 1'b1, "R5 stop ignored while count pending", mclk_en, 1);
        for (int i = 0; i < 40 && mclk_en; i++) @(negedge clk);
        do_resume();

        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule